// File: doc/BRIEF.md
# Six-Digit Stopwatch with Seven-Segment Output

This block keeps elapsed time at a resolution of one tenth of a second and drives six seven-segment digits directly. Display 0 shows tenths. Displays 2 and 1 show seconds, tens on 2 and units on 1. Displays 4 and 3 show minutes, tens on 4 and units on 3. Display 5 shows hours. An external timer supplies a one-cycle `tick_i` pulse every 100 ms. Button press events arrive as one-cycle pulses on `start_i`, `stop_i` and `clear_i`. Debouncing, synchronising those events and generating the tick all happen outside the block.

Internally the six digits form a carry chain. Each digit has its own limit: 9 for the units positions and the hours, and a parameter (default 5) for the two tens positions. An enabled tick steps the tenths digit. Each digit that wraps steps the next one. When the hours digit wraps, the whole display returns to zero. A run flag decides whether ticks are counted.

Top module: `stopwatch_hex6`

## Requirements
- R1: After reset, all six displays show the pattern for 0, and the block is stopped.
- R2: Segment bit 0 drives segment a and bit 6 drives segment g. The digit patterns are 0=0111111, 1=0000110, 2=1011011, 3=1001111, 4=1100110, 5=1101101, 6=1111101, 7=0000111, 8=1111111, 9=1101111.
- R3: While the block is running, each tick adds one tenth. A tick in the same cycle as the start that launches the run is not counted.
- R4: Ticks have no effect while the block is stopped. A stop freezes the display at its current value.
- R5: A start while running has no effect, and a stop while stopped has no effect. When start and stop arrive in the same cycle, stop wins.
- R6: Tenths wrap from 9 to 0 and carry into the seconds units (display 1). The seconds units wrap from 9 to 0 and carry into the seconds tens (display 2). The seconds tens wrap from 5 to 0 and carry into the minutes units (display 3).
- R7: Minutes follow the same 00-59 pattern on displays 4 and 3, and their wrap carries into the hours (display 5).
- R8: The hours wrap from 9 to 0, which returns every display to 0.
- R9: A clear sets all digits to 0 and leaves the block stopped. A clear wins over start, stop and tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle start request |
| stop_i | input | 1 | One-cycle stop request |
| clear_i | input | 1 | One-cycle clear request |
| tick_i | input | 1 | One-cycle 100 ms time base pulse |
| seg_o | output | 6x7 | Segment patterns; `seg_o[k]` drives display k, bit 0 = segment a |

## Verification
Single ticks are stepped one at a time through the tenths digit. This shows each of the ten segment patterns on display 0 and separates a correct carry from an off-by-one at 9. Long runs of back-to-back ticks to 59.9 s, 59:59.9 and one hour then check the mixed radices and that each carry lands on the right display. A second instance with tens limited to 0-1 reaches the hours wrap within the run. Command collisions (start with tick, start with stop, clear with start, repeated start or stop) separate the intended priorities from every other ordering.

// File: rtl/stopwatch_pkg.sv
package stopwatch_pkg;
  localparam int DIGIT_W  = 4;
  localparam int SEG_W    = 7;
  localparam int NUM_DISP = 6;

  // display positions along the carry chain
  localparam int POS_SEC_TENS = 2;
  localparam int POS_MIN_TENS = 4;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_W-1:0]   seg_t;
endpackage

// File: rtl/sw_rst_sync.sv
module sw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sw_run_ctrl.sv
module sw_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic clear_i,
  output logic run_o
);
  logic run_q;
  logic run_d;

  // priority: clear, then stop, then start
  always_comb begin
    run_d = run_q;
    if (clear_i)      run_d = 1'b0;
    else if (stop_i)  run_d = 1'b0;
    else if (start_i) run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  assign run_o = run_q;

  AST_CLEAR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !run_q);  // R9
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !run_q);  // R5
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i && !clear_i) |=> run_q);  // R3
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !stop_i && !clear_i) |=> $stable(run_q));  // R5
endmodule

// File: rtl/sw_digit.sv
module sw_digit
  import stopwatch_pkg::*;
#(
  parameter int unsigned LIMIT = 9
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr_i,
  input  logic   inc_i,
  output digit_t value_o,
  output logic   carry_o
);
  localparam digit_t LIMIT_V = digit_t'(LIMIT);

  digit_t value_q;
  digit_t value_d;
  logic   at_limit;

  assign at_limit = (value_q == LIMIT_V);

  always_comb begin
    value_d = value_q;
    if (clr_i)         value_d = '0;
    else if (inc_i) begin
      if (at_limit)    value_d = '0;
      else             value_d = value_q + digit_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value_q <= '0;
    else        value_q <= value_d;
  end

  assign value_o = value_q;
  assign carry_o = inc_i && at_limit;

  AST_DIGIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    value_q <= LIMIT_V);  // R6
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && (value_q < LIMIT_V)) |=> (value_q == $past(value_q) + digit_t'(1)));  // R3
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_o && !clr_i) |=> (value_q == '0));  // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !clr_i) |=> $stable(value_q));  // R4
endmodule

// File: rtl/sw_seg7.sv
module sw_seg7
  import stopwatch_pkg::*;
(
  input  digit_t digit_i,
  output seg_t   seg_o
);
  // bit 0 = segment a ... bit 6 = segment g
  always_comb begin
    case (digit_i)
      4'd0:    seg_o = 7'b0111111;
      4'd1:    seg_o = 7'b0000110;
      4'd2:    seg_o = 7'b1011011;
      4'd3:    seg_o = 7'b1001111;
      4'd4:    seg_o = 7'b1100110;
      4'd5:    seg_o = 7'b1101101;
      4'd6:    seg_o = 7'b1111101;
      4'd7:    seg_o = 7'b0000111;
      4'd8:    seg_o = 7'b1111111;
      4'd9:    seg_o = 7'b1101111;
      default: seg_o = 7'b0000000;
    endcase
  end
endmodule

// File: rtl/stopwatch_hex6.sv
module stopwatch_hex6
  import stopwatch_pkg::*;
#(
  parameter int unsigned UNITS_MAX = 9,
  parameter int unsigned TENS_MAX  = 5,
  parameter int unsigned HOURS_MAX = 9,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic                           stop_i,
  input  logic                           clear_i,
  input  logic                           tick_i,
  output logic [NUM_DISP-1:0][SEG_W-1:0] seg_o
);
  localparam seg_t SEG_ZERO = 7'b0111111;

  logic                rst_sync_n;
  logic                run;
  logic [NUM_DISP:0]   step;
  digit_t              digit [NUM_DISP];

  sw_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sw_run_ctrl u_run (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start_i),
    .stop_i  (stop_i),
    .clear_i (clear_i),
    .run_o   (run)
  );

  // count enable uses the run state held before this cycle's commands
  assign step[0] = run && tick_i;

  for (genvar i = 0; i < NUM_DISP; i++) begin : g_pos
    localparam int unsigned LIM = (i == NUM_DISP-1) ? HOURS_MAX :
                                  ((i == POS_SEC_TENS) || (i == POS_MIN_TENS)) ? TENS_MAX :
                                  UNITS_MAX;
    sw_digit #(.LIMIT(LIM)) u_digit (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .clr_i   (clear_i),
      .inc_i   (step[i] && !clear_i),
      .value_o (digit[i]),
      .carry_o (step[i+1])
    );
    sw_seg7 u_seg (
      .digit_i (digit[i]),
      .seg_o   (seg_o[i])
    );
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clear_i |=> (seg_o == {NUM_DISP{SEG_ZERO}}));  // R9
  AST_STOPPED_IGNORES_TICK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run && !clear_i) |=> $stable(seg_o));  // R4
  AST_ONE_CARRY_SOURCE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step[NUM_DISP] |=> (seg_o == {NUM_DISP{SEG_ZERO}}));  // R8
endmodule

// File: tb/tb_stopwatch_hex6.sv
module tb_stopwatch_hex6;
  logic clk = 1'b0;
  logic rst_n;
  logic start_i, stop_i, clear_i, tick_i;
  logic [5:0][6:0] seg_o;
  logic [5:0][6:0] seg_short;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  stopwatch_hex6 dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .clear_i(clear_i), .tick_i(tick_i), .seg_o(seg_o)
  );

  stopwatch_hex6 #(.TENS_MAX(1)) dut_short (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .clear_i(clear_i), .tick_i(tick_i), .seg_o(seg_short)
  );

  function automatic logic [6:0] pat(int d);
    case (d)
      0: return 7'b0111111;
      1: return 7'b0000110;
      2: return 7'b1011011;
      3: return 7'b1001111;
      4: return 7'b1100110;
      5: return 7'b1101101;
      6: return 7'b1111101;
      7: return 7'b0000111;
      8: return 7'b1111111;
      default: return 7'b1101111;
    endcase
  endfunction

  // expected display after n counted ticks, tens positions limited to tm
  function automatic logic [41:0] exp_disp(int n, int tm);
    logic [41:0] r;
    int b = tm + 1;
    int d [6];
    d[0] = n % 10; n = n / 10;
    d[1] = n % 10; n = n / 10;
    d[2] = n % b;  n = n / b;
    d[3] = n % 10; n = n / 10;
    d[4] = n % b;  n = n / b;
    d[5] = n % 10;
    for (int i = 0; i < 6; i++) r[i*7 +: 7] = pat(d[i]);
    return r;
  endfunction

  task automatic check(string tag, logic [41:0] act, logic [41:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmd(bit s, bit p, bit c, bit t);
    start_i = s; stop_i = p; clear_i = c; tick_i = t;
    @(negedge clk);
    start_i = 0; stop_i = 0; clear_i = 0; tick_i = 0;
  endtask

  task automatic ticks(int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset zero", seg_o, exp_disp(0, 5));
    ticks(5);
    check("R1 R4 stopped after reset", seg_o, exp_disp(0, 5));
  endtask

  task automatic t_patterns;
    cmd(1, 0, 0, 0);
    for (int k = 1; k <= 9; k++) begin
      ticks(1);
      check($sformatf("R2 R3 pattern %0d", k), seg_o, exp_disp(k, 5));
    end
    ticks(1);
    check("R6 tenths carry", seg_o, exp_disp(10, 5));
  endtask

  task automatic t_stop_start;
    cmd(0, 1, 0, 0);
    ticks(7);
    check("R4 stop freezes", seg_o, exp_disp(10, 5));
    cmd(0, 1, 0, 1);
    check("R5 stop while stopped", seg_o, exp_disp(10, 5));
    cmd(1, 1, 0, 0);
    ticks(3);
    check("R5 stop beats start", seg_o, exp_disp(10, 5));
    cmd(1, 0, 0, 1);
    check("R3 tick with start ignored", seg_o, exp_disp(10, 5));
    cmd(1, 0, 0, 1);
    check("R5 start while running", seg_o, exp_disp(11, 5));
    cmd(0, 1, 0, 1);
    check("R4 tick with stop counted", seg_o, exp_disp(12, 5));
    ticks(2);
    check("R4 stopped after stop", seg_o, exp_disp(12, 5));
  endtask

  task automatic t_clear;
    cmd(1, 0, 0, 0);
    ticks(4);
    cmd(0, 0, 1, 1);
    check("R9 clear while running", seg_o, exp_disp(0, 5));
    ticks(3);
    check("R9 stopped after clear", seg_o, exp_disp(0, 5));
    ticks(0);
    cmd(1, 0, 0, 0);
    ticks(2);
    cmd(1, 0, 1, 0);
    ticks(3);
    check("R9 clear beats start", seg_o, exp_disp(0, 5));
  endtask

  task automatic t_long;
    cmd(1, 0, 0, 0);
    ticks(599);
    check("R6 59.9 s", seg_o, exp_disp(599, 5));
    ticks(1);
    check("R6 seconds tens carry to minutes", seg_o, exp_disp(600, 5));
    ticks(35999 - 600);
    check("R7 59:59.9", seg_o, exp_disp(35999, 5));
    ticks(1);
    check("R7 minutes carry to hours", seg_o, exp_disp(36000, 5));
  endtask

  task automatic t_wrap;
    cmd(0, 0, 1, 0);
    check("R9 short clear", seg_short, exp_disp(0, 1));
    cmd(1, 0, 0, 0);
    ticks(39999);
    check("R8 short all at limit", seg_short, exp_disp(39999, 1));
    check("R7 main at 40000-1", seg_o, exp_disp(39999, 5));
    ticks(1);
    check("R8 hours wrap to zero", seg_short, exp_disp(0, 1));
    ticks(25);
    check("R8 counting resumes after wrap", seg_short, exp_disp(25, 1));
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start_i = 0; stop_i = 0; clear_i = 0; tick_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_patterns();
    t_stop_start();
    t_clear();
    t_long();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule